// File: doc/BRIEF.md
# Card Command Frame Assembler with Serial CRC-4

This block prepares the command words that a contactless reader sends to a memory card, and checks the byte a card returns to a read. A request carries a card-type code, a read/write flag, a byte index, a data byte for writes and a 12-bit response word for reads. The card-type code sets the width of the command field: 6, 9 or 11 bits for cards of 22, 256 or 1024 bytes. The command field holds the index shifted up one place, with the read/write flag in bit 0.

For a write, the block appends the data byte and a 4-bit checksum above the command field. It returns the whole frame and its length in bits. For a read, it returns the bare command with its length. It also splits the response into a data byte and a checksum nibble, recomputes the checksum and flags a mismatch. The checksum is computed one bit per clock by a serial shift register, so the latency of a request depends on the card type.

Requests enter on a valid/ready handshake. `req_ready` is high only while the block is idle. A result is held on the response port with `rsp_valid` until `rsp_ready` is seen high at a clock edge. While a result waits, no new request is taken, so back-pressure on the response port stalls the request port.

Top module: `cmdfrm_asm`

## Requirements
- R1: Card-type code 0x0D selects a 6-bit command field and 22 bytes, 0x1D selects 9 bits and 256 bytes, and 0x3D selects 11 bits and 1024 bytes. Any other code answers with `rsp_type_err` set, `rsp_len` = 0 and `rsp_frame` = 0.
- R2: The command field is (index << 1) | rw, with rw = 1 for read and 0 for write, in the low bits of `rsp_frame`. A read answers with `rsp_frame` equal to that command and `rsp_len` equal to the command width.
- R3: A write answers with the command in bits [w-1:0], the data byte in bits [w+7:w] and the checksum in bits [w+11:w+8], where w is the command width. `rsp_len` = w + 12.
- R4: The checksum starts from 0x5 and runs over the bit string (data << w) | command, which is w + 8 bits long, least significant bit first. At each bit, fb = c[0] xor bit, then c = c >> 1, and c is XORed with 0xC when fb is 1.
- R5: For a read, `req_resp[7:0]` is the data byte and `req_resp[11:8]` is the received checksum. `rsp_byte` returns the data byte. `rsp_crc_err` is 1 exactly when the received checksum differs from the checksum of R4 computed over that byte.
- R6: An index equal to or above the card size answers with `rsp_range_err` set, `rsp_len` = 0 and `rsp_frame` = 0.
- R7: A write to index 4 or below answers with `rsp_lock_err` set and no frame. Reads of those indices are served normally. At most one error flag is set, with priority type, then range, then lock.
- R8: For a request without errors, `rsp_valid` rises w + 8 clock edges after the accepting edge, and `crc_done` pulses for one cycle with it. A request with an error is answered right after the accepting edge.
- R9: `req_ready` is low from acceptance until the response is taken. A response held with `rsp_ready` low keeps every response output stable. A request offered while the block is busy is not accepted and leaves no response behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken at this edge |
| req_card_type | input | 8 | Card-type code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 10 | Byte index on the card |
| req_data | input | 8 | Data byte for a write |
| req_resp | input | 12 | Card response for a read: checksum in [11:8], data in [7:0] |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Result taken at this edge |
| rsp_frame | output | 23 | Frame word, least significant bit sent first |
| rsp_len | output | 5 | Frame length in bits, 0 for none |
| rsp_byte | output | 8 | Data byte of a read response |
| rsp_crc_err | output | 1 | Read response checksum mismatch |
| rsp_type_err | output | 1 | Unknown card type |
| rsp_range_err | output | 1 | Index beyond card size |
| rsp_lock_err | output | 1 | Write to a read-only index |
| crc_done | output | 1 | One-cycle pulse when the last checksum bit is processed |

## Verification
The bench sweeps all three card types over the low indices and around each size boundary. It issues a write, a read with a correct checksum and a read with a corrupted one, and compares each against a bench model of the serial checksum.
- Exact boundaries: the bench tests index 4 against index 5 for the lock and the card size against size minus one. A design with an off-by-one compare would refuse a legal byte or emit a frame past the card.
- Unknown card codes that differ from a valid one by a single bit: a decoder that ignores a bit would accept them.
- Fixed checksum in a read: a checksum that ignored the command field or used the wrong preset would pass the good reads only by accident.
- Latency per card type: a miscounted bit string shows up as the wrong latency.
- Held response: the bench holds the response and offers a rival request. A design that leaks the busy request would change the held frame or produce a phantom second response.

// File: rtl/cmdfrm_pkg.sv
package cmdfrm_pkg;
  localparam int IDX_W    = 10;
  localparam int DATA_W   = 8;
  localparam int CRC_W    = 4;
  localparam int RESP_W   = DATA_W + CRC_W;
  localparam int CMD_MAX  = IDX_W + 1;
  localparam int STR_W    = CMD_MAX + DATA_W;
  localparam int FRAME_W  = STR_W + CRC_W;
  localparam int LEN_W    = $clog2(FRAME_W + 1);
  localparam int SIZE_W   = IDX_W + 1;

  typedef struct packed {
    logic              known;
    logic [LEN_W-1:0]  cmd_w;
    logic [SIZE_W-1:0] size;
  } card_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_RESP} fsm_t;
endpackage

// File: rtl/cmdfrm_card_dec.sv
module cmdfrm_card_dec
  import cmdfrm_pkg::*;
(
  input  logic [7:0] card_type,
  output card_cfg_t  cfg
);
  always_comb begin
    cfg = '0;
    unique case (card_type)
      8'h0D: begin cfg.known = 1'b1; cfg.cmd_w = LEN_W'(6);  cfg.size = SIZE_W'(22);   end
      8'h1D: begin cfg.known = 1'b1; cfg.cmd_w = LEN_W'(9);  cfg.size = SIZE_W'(256);  end
      8'h3D: begin cfg.known = 1'b1; cfg.cmd_w = LEN_W'(11); cfg.size = SIZE_W'(1024); end
      default: cfg = '0;
    endcase
  end
endmodule

// File: rtl/cmdfrm_crc4.sv
module cmdfrm_crc4 #(
  parameter int              W    = 4,
  parameter logic [W-1:0]    POLY = 4'hC,
  parameter logic [W-1:0]    INIT = 4'h5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         en,
  input  logic         bit_in,
  output logic [W-1:0] crc
);
  logic         fb;
  logic [W-1:0] crc_nxt;

  always_comb begin
    fb      = crc[0] ^ bit_in;
    crc_nxt = (crc >> 1) ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc <= INIT;
    else if (init) crc <= INIT;
    else if (en)   crc <= crc_nxt;
  end

  AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !en) |=> $stable(crc)); // R4
endmodule

// File: rtl/cmdfrm_pack.sv
module cmdfrm_pack
  import cmdfrm_pkg::*;
(
  input  logic               wr,
  input  logic               err,
  input  logic [LEN_W-1:0]   cmd_w,
  input  logic [IDX_W-1:0]   idx,
  input  logic [DATA_W-1:0]  data,
  input  logic [CRC_W-1:0]   crc,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   len
);
  logic [CMD_MAX-1:0] cmd;

  always_comb begin
    cmd = {idx, ~wr};
    if (err) begin
      frame = '0;
      len   = '0;
    end else if (wr) begin
      frame = FRAME_W'(cmd)
            | (FRAME_W'(data) << cmd_w)
            | (FRAME_W'(crc) << (cmd_w + LEN_W'(DATA_W)));
      len   = cmd_w + LEN_W'(DATA_W + CRC_W);
    end else begin
      frame = FRAME_W'(cmd);
      len   = cmd_w;
    end
  end
endmodule

// File: rtl/cmdfrm_asm.sv
module cmdfrm_asm
  import cmdfrm_pkg::*;
#(
  parameter logic [CRC_W-1:0] CRC_POLY  = 4'hC,
  parameter logic [CRC_W-1:0] CRC_INIT  = 4'h5,
  parameter int               LOCK_MAX  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [7:0]         req_card_type,
  input  logic               req_write,
  input  logic [IDX_W-1:0]   req_index,
  input  logic [DATA_W-1:0]  req_data,
  input  logic [RESP_W-1:0]  req_resp,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [FRAME_W-1:0] rsp_frame,
  output logic [LEN_W-1:0]   rsp_len,
  output logic [DATA_W-1:0]  rsp_byte,
  output logic               rsp_crc_err,
  output logic               rsp_type_err,
  output logic               rsp_range_err,
  output logic               rsp_lock_err,
  output logic               crc_done
);
  fsm_t               state;
  card_cfg_t          cfg_in;
  logic               accept, t_err, r_err, l_err;
  logic [DATA_W-1:0]  dsel;
  logic [STR_W-1:0]   str_in, sreg;
  logic [LEN_W-1:0]   cnt, cmdw_q;
  logic               wr_q, terr_q, rerr_q, lerr_q, any_err;
  logic [IDX_W-1:0]   idx_q;
  logic [DATA_W-1:0]  data_q;
  logic [RESP_W-1:0]  resp_q;
  logic [CRC_W-1:0]   crc;

  cmdfrm_card_dec u_dec (.card_type(req_card_type), .cfg(cfg_in));

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    t_err  = !cfg_in.known;
    r_err  = cfg_in.known && ({1'b0, req_index} >= cfg_in.size);
    l_err  = cfg_in.known && !r_err && req_write && (req_index <= IDX_W'(LOCK_MAX));
    dsel   = req_write ? req_data : req_resp[DATA_W-1:0];
    str_in = (STR_W'(dsel) << cfg_in.cmd_w) | STR_W'({req_index, ~req_write});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sreg     <= '0;
      cnt      <= '0;
      cmdw_q   <= '0;
      wr_q     <= 1'b0;
      terr_q   <= 1'b0;
      rerr_q   <= 1'b0;
      lerr_q   <= 1'b0;
      idx_q    <= '0;
      data_q   <= '0;
      resp_q   <= '0;
      crc_done <= 1'b0;
    end else begin
      crc_done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          sreg   <= str_in;
          cnt    <= cfg_in.cmd_w + LEN_W'(DATA_W);
          cmdw_q <= cfg_in.cmd_w;
          wr_q   <= req_write;
          terr_q <= t_err;
          rerr_q <= r_err;
          lerr_q <= l_err;
          idx_q  <= req_index;
          data_q <= req_data;
          resp_q <= req_resp;
          state  <= (t_err || r_err || l_err) ? ST_RESP : ST_RUN;
        end
        ST_RUN: begin
          sreg <= sreg >> 1;
          cnt  <= cnt - LEN_W'(1);
          if (cnt == LEN_W'(1)) begin
            state    <= ST_RESP;
            crc_done <= 1'b1;
          end
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  cmdfrm_crc4 #(.W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk(clk), .rst_n(rst_n), .init(accept), .en(state == ST_RUN),
    .bit_in(sreg[0]), .crc(crc)
  );

  assign any_err = terr_q || rerr_q || lerr_q;

  cmdfrm_pack u_pack (
    .wr(wr_q), .err(any_err), .cmd_w(cmdw_q), .idx(idx_q), .data(data_q),
    .crc(crc), .frame(rsp_frame), .len(rsp_len)
  );

  assign rsp_valid     = (state == ST_RESP);
  assign rsp_type_err  = rsp_valid && terr_q;
  assign rsp_range_err = rsp_valid && rerr_q;
  assign rsp_lock_err  = rsp_valid && lerr_q;
  assign rsp_byte      = (rsp_valid && !wr_q && !any_err) ? resp_q[DATA_W-1:0] : '0;
  assign rsp_crc_err   = rsp_valid && !wr_q && !any_err && (crc != resp_q[RESP_W-1:DATA_W]);

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_frame) && $stable(rsp_len)
                                   && $stable(rsp_crc_err) && $stable(rsp_byte))); // R9
  AST_ERR_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_type_err || rsp_range_err || rsp_lock_err)) |-> (rsp_len == '0)); // R6
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0({rsp_type_err, rsp_range_err, rsp_lock_err, rsp_crc_err})); // R7
  AST_DONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    crc_done |-> (rsp_valid && !$past(rsp_valid))); // R8
  AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> !req_ready); // R9
endmodule

// File: tb/cmdfrm_asm_tb.sv
module cmdfrm_asm_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic        req_ready, rsp_valid, rsp_crc_err, rsp_type_err, rsp_range_err, rsp_lock_err, crc_done;
  logic [7:0]  req_card_type = 8'h0D, req_data = 8'h00, rsp_byte;
  logic [9:0]  req_index = '0;
  logic [11:0] req_resp = '0;
  logic [22:0] rsp_frame;
  logic [4:0]  rsp_len;
  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  cmdfrm_asm u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_card_type(req_card_type), .req_write(req_write), .req_index(req_index),
    .req_data(req_data), .req_resp(req_resp), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_frame(rsp_frame), .rsp_len(rsp_len), .rsp_byte(rsp_byte), .rsp_crc_err(rsp_crc_err),
    .rsp_type_err(rsp_type_err), .rsp_range_err(rsp_range_err), .rsp_lock_err(rsp_lock_err),
    .crc_done(crc_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int cw_of(input logic [7:0] t);
    case (t) 8'h0D: return 6; 8'h1D: return 9; 8'h3D: return 11; default: return 0; endcase
  endfunction
  function automatic int size_of(input logic [7:0] t);
    case (t) 8'h0D: return 22; 8'h1D: return 256; 8'h3D: return 1024; default: return 0; endcase
  endfunction
  function automatic logic [3:0] crc_ref(input longint s, input int n);
    logic [3:0] c;
    c = 4'h5;
    for (int i = 0; i < n; i++) begin
      logic fb;
      fb = c[0] ^ s[i];
      c  = c >> 1;
      if (fb) c = c ^ 4'hC;
    end
    return c;
  endfunction

  task automatic txn(input logic [7:0] t, input logic wr, input int idx,
                     input logic [7:0] d, input logic [11:0] resp);
    int cw, sz, lat, explat;
    bit te, re, le;
    longint cmd, ef;
    int el;
    logic [3:0] c;
    cw = cw_of(t); sz = size_of(t);
    te = (cw == 0);
    re = !te && (idx >= sz);
    le = !te && !re && wr && (idx <= 4);
    cmd = (longint'(idx) << 1) | longint'(!wr);
    if (te || re || le) begin ef = 0; el = 0; explat = 0; end
    else if (wr) begin
      c  = crc_ref((longint'(d) << cw) | cmd, cw + 8);
      ef = cmd | (longint'(d) << cw) | (longint'(c) << (cw + 8));
      el = cw + 12; explat = cw + 8;
    end else begin
      ef = cmd; el = cw; explat = cw + 8;
    end
    @(negedge clk);
    chk(req_ready === 1'b1, "R9", "ready when idle", req_ready, 1);
    req_card_type = t; req_write = wr; req_index = 10'(idx); req_data = d; req_resp = resp;
    req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 100) begin @(posedge clk); #1; lat++; end
    chk(lat == explat, "R8", "latency", lat, explat);
    chk(rsp_type_err === te, "R1", "type_err", rsp_type_err, te);
    chk(rsp_range_err === re, "R6", "range_err", rsp_range_err, re);
    chk(rsp_lock_err === le, "R7", "lock_err", rsp_lock_err, le);
    chk(longint'(rsp_len) == longint'(el), wr ? "R3" : "R2", "len", rsp_len, el);
    chk(longint'(rsp_frame) == ef, wr ? "R3" : "R2", "frame", rsp_frame, ef);
    if (!explat) chk(crc_done === 1'b0, "R8", "no done on error", crc_done, 0);
    else         chk(crc_done === 1'b1, "R8", "done pulse", crc_done, 1);
    if (!wr && !te && !re) begin
      c = crc_ref((longint'(resp[7:0]) << cw) | cmd, cw + 8);
      chk(rsp_byte == resp[7:0], "R5", "byte", rsp_byte, resp[7:0]);
      chk(rsp_crc_err === (c != resp[11:8]), "R4", "crc_err", rsp_crc_err, c != resp[11:8]);
    end
    @(posedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] types [3];
    types[0] = 8'h0D; types[1] = 8'h1D; types[2] = 8'h3D;
    repeat (3) @(posedge clk);
    #1;
    chk(rsp_valid === 1'b0, "R9", "reset rsp_valid", rsp_valid, 0);
    chk(req_ready === 1'b1, "R9", "reset req_ready", req_ready, 1);
    rst_n = 1'b1;

    // R1: unknown codes, including single-bit neighbours of legal ones
    txn(8'h00, 1'b0, 0, 8'h00, 12'h000);
    txn(8'h0C, 1'b0, 1, 8'h00, 12'h000);
    txn(8'h1C, 1'b1, 9, 8'h11, 12'h000);
    txn(8'h2D, 1'b0, 3, 8'h00, 12'h000);
    txn(8'h7D, 1'b1, 8, 8'h22, 12'h000);
    txn(8'hFF, 1'b0, 0, 8'h00, 12'h000);

    for (int k = 0; k < 3; k++) begin
      int sz, cw;
      sz = size_of(types[k]); cw = cw_of(types[k]);
      for (int idx = 0; idx < 34; idx++) begin
        int ix;
        logic [7:0] d;
        logic [3:0] gc;
        ix = (idx < 32) ? idx : ((idx == 32) ? sz - 1 : sz);
        if (ix > 1023) ix = 1023;
        d  = 8'((ix * 37 + 5 + k * 11) & 255);
        gc = crc_ref((longint'(d) << cw) | ((longint'(ix) << 1) | 1), cw + 8);
        txn(types[k], 1'b1, ix, d, 12'h000);                       // R3 R7
        txn(types[k], 1'b0, ix, 8'h00, {gc, d});                   // R5 good
        txn(types[k], 1'b0, ix, 8'h00, {gc ^ 4'((ix % 15) + 1), d}); // R5 bad
      end
    end

    // R9: held response, rival request while busy
    begin
      logic [22:0] held;
      logic [4:0]  hlen;
      @(negedge clk);
      rsp_ready = 1'b0;
      req_card_type = 8'h1D; req_write = 1'b1; req_index = 10'd100; req_data = 8'hA5;
      req_valid = 1'b1;
      @(posedge clk); #1;
      req_valid = 1'b0;
      while (!rsp_valid) begin @(posedge clk); #1; end
      held = rsp_frame; hlen = rsp_len;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_index = 10'd7;
        @(posedge clk); #1;
        chk(rsp_valid === 1'b1, "R9", "held valid", rsp_valid, 1);
        chk(rsp_frame == held && rsp_len == hlen, "R9", "held frame", rsp_frame, held);
        chk(req_ready === 1'b0, "R9", "busy ready", req_ready, 0);
      end
      @(negedge clk);
      req_valid = 1'b0; rsp_ready = 1'b1;
      @(posedge clk); #1;
      chk(rsp_valid === 1'b0, "R9", "response taken", rsp_valid, 0);
      repeat (15) begin
        @(posedge clk); #1;
        chk(rsp_valid === 1'b0, "R9", "no phantom response", rsp_valid, 0);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule